// File: doc/BRIEF.md
# Boot ROM Shadow Controller

This block steers accesses that fall in two ROM windows during start-up of a 32-bit processor system. Out of reset, reads of either window go to a slow boot flash, with wait states inserted, while writes to the same addresses fall through to the RAM underneath. Boot code uses this to copy itself, or an operating system image, into that RAM. A single access to a dedicated trigger address then retires the flash for good. From that point, reads of the windows come from RAM and writes to them are refused with a one-cycle bus-error flag, so the copied code is read-only.

The windows are 128 KB and 64 KB, which is 192 KB in total. A strap input tells the block whether the flash is 8 or 16 bits wide, and that choice sets the wait-state count. Every other address below the RAM limit is passed to RAM unchanged in both phases.

The controller has three states:
- `ST_BOOT`: flash is mapped.
- `ST_FLASH_WAIT`: a flash read is stretched.
- `ST_RUN`: flash is unmapped and protection is armed.

It has four transitions:
- `ST_BOOT`→`ST_FLASH_WAIT` on a window read.
- `ST_FLASH_WAIT`→`ST_BOOT` when the wait counter reaches zero.
- `ST_BOOT`→`ST_RUN` on an access to the trigger address.
- `ST_RUN`→`ST_RUN` for every other case.

Only reset leaves `ST_RUN`.

Top module: `boot_shadow_ctrl`

## Requirements
- R1: After reset, with no request active, flash_sel, ram_sel, ram_we, wait_req and bus_err are all 0.
- R2: Window 0 covers 0x0000_0000–0x0001_FFFF and window 1 covers 0x0030_0000–0x0030_FFFF. The byte just before a window and the byte just after it are not window addresses.
- R3: Before unmap, a read of either window asserts flash_sel and holds wait_req high for WS cycles, where WS is 5 when strap_narrow=1 and 3 when strap_narrow=0. One further cycle follows with flash_sel high and wait_req low.
- R4: Before unmap, a write to either window asserts ram_sel and ram_we, with no flash_sel, no wait_req and no bus_err.
- R5: An access to 0x00FF_0000 before unmap removes the flash. Later window reads assert ram_sel only, with no flash_sel and no wait_req.
- R6: After unmap, a write to either window asserts bus_err in that cycle only, with ram_sel and ram_we low. bus_err is 0 in the cycle that follows.
- R7: Once unmapped, further trigger accesses change nothing. Only reset brings the flash back.
- R8: An address below 0x0080_0000 that lies outside both windows asserts ram_sel, and asserts ram_we when bus_write=1, in either phase.
- R9: An address at or above 0x0080_0000, including the trigger address, asserts no output.
- R10: flash_sel and ram_sel are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, returns the map to flash |
| bus_addr | input | 32 | Processor byte address |
| bus_req | input | 1 | Access in progress; held until wait_req is low |
| bus_write | input | 1 | 1 = write, 0 = read |
| strap_narrow | input | 1 | 1 = 8-bit flash, 0 = 16-bit flash |
| flash_sel | output | 1 | Flash chip select |
| ram_sel | output | 1 | RAM select |
| ram_we | output | 1 | RAM write enable |
| wait_req | output | 1 | Stretch the current cycle |
| bus_err | output | 1 | Blocked write to protected RAM |

## Verification
The bench builds the block with its default parameters: 3 wait states for wide flash, 5 for narrow flash, the two windows at the addresses above, and the trigger at 0x00FF_0000. With these values both wait-state lengths can be reached by flipping the strap between accesses. Because the window edges sit at small addresses, random addresses land on them and on the bytes next to them. The random stream also issues triggers and resets, so both phases and the return to flash on reset are visited many times.

// File: rtl/boot_shadow_pkg.sv
package boot_shadow_pkg;
    typedef enum logic [1:0] {
        ST_BOOT       = 2'd0,
        ST_FLASH_WAIT = 2'd1,
        ST_RUN        = 2'd2
    } shadow_state_t;
endpackage

// File: rtl/bs_window_dec.sv
module bs_window_dec #(
    parameter logic [31:0] BASE  = 32'h0,
    parameter logic [31:0] BYTES = 32'h1_0000
) (
    input  logic [31:0] addr,
    output logic        hit
);
    localparam logic [32:0] LIMIT = {1'b0, BASE} + {1'b0, BYTES};

    always_comb begin
        hit = ({1'b0, addr} >= {1'b0, BASE}) && ({1'b0, addr} < LIMIT);
    end
endmodule

// File: rtl/bs_wait_timer.sv
module bs_wait_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          cnt_zero
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    always_comb begin
        cnt_zero = (cnt == '0);
    end
endmodule

// File: rtl/boot_shadow_ctrl.sv
module boot_shadow_ctrl
    import boot_shadow_pkg::*;
#(
    parameter logic [31:0] WIN0_BASE  = 32'h0000_0000,
    parameter logic [31:0] WIN0_BYTES = 32'h0002_0000,
    parameter logic [31:0] WIN1_BASE  = 32'h0030_0000,
    parameter logic [31:0] WIN1_BYTES = 32'h0001_0000,
    parameter logic [31:0] RAM_LIMIT  = 32'h0080_0000,
    parameter logic [31:0] TRIG_ADDR  = 32'h00FF_0000,
    parameter int          WS_WIDE    = 3,
    parameter int          WS_NARROW  = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] bus_addr,
    input  logic        bus_req,
    input  logic        bus_write,
    input  logic        strap_narrow,
    output logic        flash_sel,
    output logic        ram_sel,
    output logic        ram_we,
    output logic        wait_req,
    output logic        bus_err
);
    localparam int NWIN   = 2;
    localparam int WS_MAX = (WS_WIDE > WS_NARROW) ? WS_WIDE : WS_NARROW;
    localparam int CW     = $clog2(WS_MAX + 1);

    shadow_state_t state, state_nx;
    logic [NWIN-1:0] win_hit;
    logic            any_win, ram_hit, trig_hit;
    logic            flash_rd, tmr_load, cnt_zero;
    logic [CW-1:0]   ws_sel, tmr_val;

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        bs_window_dec #(
            .BASE  ((g == 0) ? WIN0_BASE  : WIN1_BASE),
            .BYTES ((g == 0) ? WIN0_BYTES : WIN1_BYTES)
        ) u_dec (
            .addr (bus_addr),
            .hit  (win_hit[g])
        );
    end

    always_comb begin
        any_win  = |win_hit;
        ram_hit  = bus_addr < RAM_LIMIT;
        trig_hit = bus_addr == TRIG_ADDR;
        ws_sel   = strap_narrow ? CW'(WS_NARROW) : CW'(WS_WIDE);
        tmr_val  = ws_sel - 1'b1;
        flash_rd = bus_req && any_win && !bus_write;
        tmr_load = (state == ST_BOOT) && flash_rd;
    end

    bs_wait_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .cnt_zero (cnt_zero)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_BOOT;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_BOOT: begin
                if (flash_rd)                  state_nx = ST_FLASH_WAIT;
                else if (bus_req && trig_hit)  state_nx = ST_RUN;
            end
            ST_FLASH_WAIT: begin
                if (cnt_zero) state_nx = ST_BOOT;
            end
            ST_RUN: state_nx = ST_RUN;
            default: state_nx = ST_BOOT;
        endcase
    end

    // outputs
    always_comb begin
        flash_sel = 1'b0;
        ram_sel   = 1'b0;
        ram_we    = 1'b0;
        wait_req  = 1'b0;
        bus_err   = 1'b0;
        unique case (state)
            ST_BOOT: begin
                if (bus_req) begin
                    if (any_win) begin
                        if (bus_write) begin
                            ram_sel = 1'b1;
                            ram_we  = 1'b1;
                        end else begin
                            flash_sel = 1'b1;
                            wait_req  = 1'b1;
                        end
                    end else if (ram_hit) begin
                        ram_sel = 1'b1;
                        ram_we  = bus_write;
                    end
                end
            end
            ST_FLASH_WAIT: begin
                flash_sel = 1'b1;
                wait_req  = !cnt_zero;
            end
            ST_RUN: begin
                if (bus_req) begin
                    if (any_win) begin
                        if (bus_write) bus_err = 1'b1;
                        else           ram_sel = 1'b1;
                    end else if (ram_hit) begin
                        ram_sel = 1'b1;
                        ram_we  = bus_write;
                    end
                end
            end
            default: ;
        endcase
    end

    // checker state: length of the current wait run
    logic [CW:0] wait_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        wait_len <= '0;
        else if (wait_req) wait_len <= wait_len + 1'b1;
        else               wait_len <= '0;
    end

    AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(flash_sel && ram_sel)); // R10
    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_RUN |=> state == ST_RUN); // R7
    AST_NO_FLASH_AFTER_UNMAP: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_RUN |-> !flash_sel && !wait_req); // R5
    AST_PROT_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err |-> !ram_we && !ram_sel && bus_write)); // R6
    AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        wait_req |-> wait_len < (CW+1)'(WS_MAX)); // R3
    AST_WAIT_WITH_FLASH: assert property (@(posedge clk) disable iff (!rst_n)
        wait_req |-> flash_sel); // R3
endmodule

// File: tb/tb_boot_shadow_ctrl.sv
module tb_boot_shadow_ctrl;
    localparam logic [31:0] TRIG = 32'h00FF_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_req = 1'b0;
    logic        bus_write = 1'b0;
    logic        strap_narrow = 1'b0;
    logic        flash_sel, ram_sel, ram_we, wait_req, bus_err;

    int checks = 0;
    int fails  = 0;
    bit run_ph = 1'b0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    boot_shadow_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_req(bus_req),
        .bus_write(bus_write), .strap_narrow(strap_narrow),
        .flash_sel(flash_sel), .ram_sel(ram_sel), .ram_we(ram_we),
        .wait_req(wait_req), .bus_err(bus_err)
    );

    function automatic bit is_win(logic [31:0] a);
        return (a < 32'h0002_0000) || (a >= 32'h0030_0000 && a < 32'h0031_0000);
    endfunction

    // expected {flash_sel, ram_sel, ram_we, wait_req, bus_err} for single-cycle accesses
    function automatic logic [4:0] exp_vec(bit run, logic [31:0] a, bit we);
        if (is_win(a)) begin
            if (!run && we) return 5'b01100;
            if (run && we)  return 5'b00001;
            if (run)        return 5'b01000;
            return 5'b10010;
        end
        if (a < 32'h0080_0000) return {2'b01, we, 2'b00};
        return 5'b00000;
    endfunction

    function automatic string tag_of(bit run, logic [31:0] a, bit we);
        if (a == TRIG)               return run ? "R7" : "R5";
        if (is_win(a) && !run && we) return "R4";
        if (is_win(a) && run && we)  return "R6";
        if (is_win(a) && run)        return "R5";
        if (a < 32'h0080_0000)       return "R8";
        return "R9";
    endfunction

    task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: outputs {flash,ram,we,wait,err} = %b, expected %b", tag, act, exp);
        end
        if (flash_sel && ram_sel) begin
            fails++;
            $display("FAIL R10: flash_sel and ram_sel both high, actual 1 1, expected not both");
        end
    endtask

    function automatic logic [4:0] outs();
        return {flash_sel, ram_sel, ram_we, wait_req, bus_err};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        bus_req = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        run_ph = 1'b0;
    endtask

    task automatic idle(string tag);
        @(negedge clk);
        bus_req = 1'b0;
        #2 check(tag, outs(), 5'b00000);
    endtask

    task automatic access(logic [31:0] a, bit we, bit narrow, string tag);
        int ws;
        @(negedge clk);
        bus_addr = a; bus_write = we; bus_req = 1'b1; strap_narrow = narrow;
        if (!run_ph && is_win(a) && !we) begin
            ws = narrow ? 5 : 3;
            for (int i = 0; i <= ws; i++) begin
                #2 check(tag, outs(), {1'b1, 2'b00, (i < ws), 1'b0});
                if (i < ws) @(negedge clk);
            end
        end else begin
            #2 check(tag, outs(), exp_vec(run_ph, a, we));
        end
        if (a == TRIG) run_ph = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd20240412));
        do_reset();
        idle("R1");
        access(32'h0000_0000, 1'b0, 1'b0, "R3");
        access(32'h0030_FFFF, 1'b0, 1'b1, "R3");
        access(32'h0001_FFFF, 1'b0, 1'b1, "R2");
        access(32'h0002_0000, 1'b0, 1'b0, "R2");
        access(32'h002F_FFFF, 1'b1, 1'b0, "R2");
        access(32'h0031_0000, 1'b0, 1'b0, "R2");
        access(32'h0000_1000, 1'b1, 1'b0, "R4");
        access(32'h0030_0004, 1'b1, 1'b1, "R4");
        access(32'h0050_0000, 1'b1, 1'b0, "R8");
        access(32'h0100_0000, 1'b1, 1'b0, "R9");
        access(TRIG, 1'b0, 1'b0, "R9");
        access(32'h0000_0010, 1'b0, 1'b0, "R5");
        access(32'h0030_0010, 1'b1, 1'b0, "R6");
        idle("R6");
        access(TRIG, 1'b1, 1'b0, "R7");
        access(32'h0001_0000, 1'b0, 1'b1, "R7");
        access(32'h0007_0000, 1'b0, 1'b0, "R8");
        do_reset();
        access(32'h0001_0000, 1'b0, 1'b1, "R7");

        for (int n = 0; n < 600; n++) begin
            logic [31:0] a;
            bit we, nr;
            int k;
            k  = $urandom_range(0, 99);
            we = $urandom_range(0, 1) == 1;
            nr = $urandom_range(0, 1) == 1;
            if (k < 2) begin
                do_reset();
                idle("R1");
                continue;
            end
            if (k < 5)       a = TRIG;
            else if (k < 35) a = $urandom_range(0, 32'h0002_0040);
            else if (k < 60) a = 32'h002F_FFC0 + $urandom_range(0, 32'h0001_0080);
            else if (k < 85) a = $urandom_range(0, 32'h0080_0010);
            else             a = 32'h007F_FFF0 + $urandom_range(0, 32'h0100_0000);
            if (!run_ph && is_win(a) && !we)
                access(a, we, nr, is_win(a) ? "R3" : "R2");
            else
                access(a, we, nr, tag_of(run_ph, a, we));
            if ($urandom_range(0, 3) == 0) idle(run_ph ? "R6" : "R1");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not end, actual hung, expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule